// File: doc/BRIEF.md
# Interleaved Burst Address Generator

This block produces the word address that a synchronous burst memory uses internally. A new base address is taken from the external address bus when one of two active-low address strobes is accepted. After that, an active-low advance input moves the two least significant address bits through a four-beat interleaved order. The bits above them keep the loaded value. When advance is sampled high the address holds, which inserts a wait state.

The two strobes are qualified in different ways. The processor strobe is honoured only while the primary active-low chip enable is low. If it is honoured while a secondary enable is inactive, the block enters the deselected state. The controller strobe loads only when every enable is active, and in any other case it deselects. The enables are examined only in cycles where a strobe acts, so changing them in the middle of a burst has no effect. When both strobes are low and the primary enable is low, the processor path decides the cycle. The memory array, the data path and the output drivers are not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: Synchronous active-high `rst` clears `word_addr` to 0 and `sel_active` to 0 on the next rising edge.
- R2: When `cstrb_n` is low, `pstrb_n` is not accepted, `en_pri_n`=0, `en_aux_n`=0 and `en_aux`=1, the edge loads `ext_addr` into `word_addr` and sets `sel_active` to 1.
- R3: When `cstrb_n` is low, `pstrb_n` is not accepted, and any enable is inactive, the edge clears `sel_active` and leaves `word_addr` unchanged.
- R4: When `pstrb_n` and `en_pri_n` are both low and both secondary enables are active, the edge loads `ext_addr` and sets `sel_active`, whatever `cstrb_n` is.
- R5: While `en_pri_n` is high, a low `pstrb_n` is ignored. With `cstrb_n` high it neither loads nor deselects, and the burst continues according to `adv_n`.
- R6: When `pstrb_n` and `en_pri_n` are both low and a secondary enable is inactive (`en_aux_n`=1 or `en_aux`=0), the edge clears `sel_active` and leaves `word_addr` unchanged.
- R7: Each edge with `adv_n` low, no accepted strobe and `sel_active`=1 advances the burst. Beat k (k = 0 for the loaded address) has low bits equal to the base low bits XOR k. The resulting orders are: from 00: 00,01,10,11. From 01: 01,00,11,10. From 10: 10,11,00,01. From 11: 11,10,01,00.
- R8: After the fourth beat the low bits return to the base value, and the sequence repeats for as long as advance continues.
- R9: An edge with `adv_n` high and no strobe leaves `word_addr` unchanged (wait state).
- R10: `word_addr[14:2]` keeps the loaded value through every beat of a burst.
- R11: An accepted strobe during a burst restarts the sequence at the new base, with beat count zero.
- R12: While `sel_active` is 0, a low `adv_n` does not change `word_addr`.
- R13: Changing the enables in cycles with no strobe low has no effect on `word_addr` or `sel_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 15 | External base address |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_pri_n | input | 1 | Primary chip enable, active low |
| en_aux_n | input | 1 | Secondary chip enable, active low |
| en_aux | input | 1 | Secondary chip enable, active high |
| word_addr | output | 15 | Current internal word address |
| sel_active | output | 1 | Block selected (last strobe loaded) |

## Verification
The assertions assume that every input is a 2-state value and is stable at each rising edge. They also assume that the strobe, advance and enable inputs are all sampled together, so that the decision in each cycle comes from a single consistent set of inputs. The bench changes every input 1 ns after a rising edge and samples the outputs at that same point. No input therefore moves close to the sampling edge, and each check sees exactly one edge's effect. Enables are toggled only in cycles with no strobe, or in cycles that intend to deselect, which matches the rule that the enables matter only on strobe cycles.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DESEL = 2'd2,
    ACT_STEP  = 2'd3
  } burst_act_e;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_pkg::*;
(
  input  logic       pstrb_n,
  input  logic       cstrb_n,
  input  logic       adv_n,
  input  logic       en_pri_n,
  input  logic       en_aux_n,
  input  logic       en_aux,
  input  logic       active,
  output burst_act_e act
);
  logic aux_ok;
  logic all_ok;
  logic p_take;

  assign aux_ok = !en_aux_n && en_aux;
  assign all_ok = aux_ok && !en_pri_n;
  // processor strobe counts only with the primary enable low; it wins over the controller strobe
  assign p_take = !pstrb_n && !en_pri_n;

  always_comb begin
    if (p_take) begin
      act = aux_ok ? ACT_LOAD : ACT_DESEL;
    end else if (!cstrb_n) begin
      act = all_ok ? ACT_LOAD : ACT_DESEL;
    end else if (!adv_n && active) begin
      act = ACT_STEP;
    end else begin
      act = ACT_HOLD;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  burst_act_e            act,
  output logic [BURST_BITS-1:0] beat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      beat <= '0;
    end else begin
      case (act)
        ACT_LOAD: beat <= '0;
        ACT_STEP: beat <= beat + 1'b1; // wraps naturally after the last beat
        default:  beat <= beat;
      endcase
    end
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_act_e        act,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base,
  output logic              active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      active <= 1'b0;
    end else begin
      case (act)
        ACT_LOAD: begin
          base   <= ext_addr;
          active <= 1'b1;
        end
        ACT_DESEL: active <= 1'b0;
        default: begin
          base   <= base;
          active <= active;
        end
      endcase
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              pstrb_n,
  input  logic              cstrb_n,
  input  logic              adv_n,
  input  logic              en_pri_n,
  input  logic              en_aux_n,
  input  logic              en_aux,
  output logic [ADDR_W-1:0] word_addr,
  output logic              sel_active
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  burst_act_e            act;
  logic [ADDR_W-1:0]     base;
  logic [BURST_BITS-1:0] beat;
  logic                  active;

  burst_ctl u_ctl (
    .pstrb_n  (pstrb_n),
    .cstrb_n  (cstrb_n),
    .adv_n    (adv_n),
    .en_pri_n (en_pri_n),
    .en_aux_n (en_aux_n),
    .en_aux   (en_aux),
    .active   (active),
    .act      (act)
  );

  burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_beat (
    .clk  (clk),
    .rst  (rst),
    .act  (act),
    .beat (beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .ext_addr (ext_addr),
    .base     (base),
    .active   (active)
  );

  assign word_addr[ADDR_W-1:BURST_BITS] = base[ADDR_W-1:ADDR_W-HI_W];

  // interleaved order: each low bit is the base bit XOR the beat bit
  for (genvar i = 0; i < BURST_BITS; i++) begin : g_ilv
    assign word_addr[i] = base[i] ^ beat[i];
  end

  assign sel_active = active;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W     = 15,
  parameter int BURST_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              pstrb_n,
  input logic              cstrb_n,
  input logic              adv_n,
  input logic              en_pri_n,
  input logic              en_aux_n,
  input logic              en_aux,
  input logic [ADDR_W-1:0] word_addr,
  input logic              sel_active
);
  logic aux_ok;
  logic p_take;
  assign aux_ok = !en_aux_n && en_aux;
  assign p_take = !pstrb_n && !en_pri_n;

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (word_addr == '0 && !sel_active));

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!p_take && !cstrb_n && !en_pri_n && aux_ok) |=> (word_addr == $past(ext_addr) && sel_active));

  // R3
  ctl_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!p_take && !cstrb_n && !(!en_pri_n && aux_ok)) |=> (!sel_active && $stable(word_addr)));

  // R4
  proc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (p_take && aux_ok) |=> (word_addr == $past(ext_addr) && sel_active));

  // R6
  proc_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (p_take && !aux_ok) |=> (!sel_active && $stable(word_addr)));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!p_take && cstrb_n && adv_n) |=> $stable(word_addr));

  // R10
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!p_take && cstrb_n) |=> $stable(word_addr[ADDR_W-1:BURST_BITS]));

  // R7
  step_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (!p_take && cstrb_n && !adv_n && sel_active) |=> !$stable(word_addr[BURST_BITS-1:0]));

  // R12
  idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (!p_take && cstrb_n && !sel_active) |=> ($stable(word_addr) && !sel_active));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .ext_addr   (ext_addr),
  .pstrb_n    (pstrb_n),
  .cstrb_n    (cstrb_n),
  .adv_n      (adv_n),
  .en_pri_n   (en_pri_n),
  .en_aux_n   (en_aux_n),
  .en_aux     (en_aux),
  .word_addr  (word_addr),
  .sel_active (sel_active)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          pstrb_n, cstrb_n, adv_n, en_pri_n, en_aux_n, en_aux;
  logic [AW-1:0] word_addr;
  logic          sel_active;
  int            n_chk = 0;
  int            n_err = 0;

  always #2 clk = ~clk;

  burst_addr_gen i_burst_addr_gen (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
    .adv_n(adv_n), .en_pri_n(en_pri_n), .en_aux_n(en_aux_n), .en_aux(en_aux),
    .word_addr(word_addr), .sel_active(sel_active)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pstrb_n = 1; cstrb_n = 1; adv_n = 1;
    en_pri_n = 0; en_aux_n = 0; en_aux = 1;
  endtask

  task automatic cload(input logic [AW-1:0] a);
    idle(); ext_addr = a; cstrb_n = 0;
    tick();
    idle();
  endtask

  task automatic t_reset();
    idle(); rst = 1; ext_addr = '0;
    tick(); tick();
    chk("R1 addr", word_addr, '0);
    chk("R1 sel", {14'd0, sel_active}, 15'd0);
    rst = 0;
  endtask

  task automatic t_cload();
    cload(15'h3A5C);
    chk("R2 addr", word_addr, 15'h3A5C);
    chk("R2 sel", {14'd0, sel_active}, 15'd1);
  endtask

  task automatic t_seq(input logic [1:0] s);
    logic [AW-1:0] a;
    a = {13'h0ABC, s};
    cload(a);
    chk("R7 beat0", word_addr, a);
    adv_n = 0;
    for (int k = 1; k < 9; k++) begin
      logic [1:0] kk;
      kk = k[1:0];
      tick();
      if (k < 4) chk("R7 order", word_addr, {13'h0ABC, s ^ kk});
      else       chk("R8 wrap", word_addr, {13'h0ABC, s ^ kk});
      chk("R10 upper", {2'b0, word_addr[AW-1:2]}, {2'b0, 13'h0ABC});
    end
    adv_n = 1;
  endtask

  task automatic t_wait();
    cload(15'h1230);
    adv_n = 0; tick();
    adv_n = 1; tick(); tick();
    chk("R9 hold", word_addr, 15'h1231);
    adv_n = 0; tick();
    chk("R9 resume", word_addr, 15'h1232);
    adv_n = 1;
  endtask

  task automatic t_cdesel();
    cload(15'h0444);
    en_aux = 0; cstrb_n = 0; ext_addr = 15'h7777;
    tick(); idle();
    chk("R3 sel aux", {14'd0, sel_active}, 15'd0);
    chk("R3 addr", word_addr, 15'h0444);
    cload(15'h0555);
    en_pri_n = 1; cstrb_n = 0; ext_addr = 15'h7777;
    tick(); idle();
    chk("R3 sel pri", {14'd0, sel_active}, 15'd0);
    chk("R3 addr pri", word_addr, 15'h0555);
  endtask

  task automatic t_pload();
    cload(15'h0101);
    pstrb_n = 0; cstrb_n = 1; ext_addr = 15'h6E02;
    tick(); idle();
    chk("R4 addr", word_addr, 15'h6E02);
    chk("R4 sel", {14'd0, sel_active}, 15'd1);
    pstrb_n = 0; cstrb_n = 0; ext_addr = 15'h2203;
    tick(); idle();
    chk("R4 both", word_addr, 15'h2203);
  endtask

  task automatic t_pignore();
    cload(15'h4C40);
    en_pri_n = 1; pstrb_n = 0; ext_addr = 15'h1111;
    tick();
    chk("R5 noload", word_addr, 15'h4C40);
    chk("R5 sel", {14'd0, sel_active}, 15'd1);
    adv_n = 0; tick(); idle();
    chk("R5 advances", word_addr, 15'h4C41);
  endtask

  task automatic t_pdesel();
    cload(15'h0888);
    pstrb_n = 0; en_aux_n = 1; ext_addr = 15'h1234;
    tick(); idle();
    chk("R6 sel", {14'd0, sel_active}, 15'd0);
    chk("R6 addr", word_addr, 15'h0888);
  endtask

  task automatic t_restart();
    cload(15'h0F00);
    adv_n = 0; tick(); tick();
    chk("R11 mid", word_addr, 15'h0F02);
    cstrb_n = 0; ext_addr = 15'h5003; tick();
    cstrb_n = 1; tick(); adv_n = 1;
    chk("R11 restart", word_addr, 15'h5002);
  endtask

  task automatic t_idle_adv();
    cload(15'h0246);
    en_aux = 0; cstrb_n = 0; tick(); idle();
    adv_n = 0; tick(); tick(); adv_n = 1;
    chk("R12 addr", word_addr, 15'h0246);
    chk("R12 sel", {14'd0, sel_active}, 15'd0);
  endtask

  task automatic t_en_toggle();
    cload(15'h3FF1);
    en_pri_n = 1; en_aux_n = 1; en_aux = 0; adv_n = 0;
    tick();
    chk("R13 addr", word_addr, 15'h3FF0);
    chk("R13 sel", {14'd0, sel_active}, 15'd1);
    idle();
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1; idle(); ext_addr = '0;
    #1;
    t_reset();
    t_cload();
    for (int s = 0; s < 4; s++) t_seq(s[1:0]);
    t_wait();
    t_cdesel();
    t_pload();
    t_pignore();
    t_pdesel();
    t_restart();
    t_idle_adv();
    t_en_toggle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule